// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-driven master for Clause 22 management frames on the two-wire MDC/MDIO bus to an Ethernet PHY. Software sees two 16-bit registers. The command register packs the PHY address, the PHY register number, a clock-range code, a direction flag and a busy flag. The data register holds the 16-bit value for a write, or returns the value read back from the PHY.

To write a PHY register, software first loads the data register. It then writes the command word with the busy bit set. To read, it writes the command word with the direction flag clear. In both cases it polls busy until the flag clears, and after a read it collects the result from the data register.

The controller derives MDC from the system clock using a divider chosen by the clock-range code. It shifts the 64-bit frame out MSB first, releases the data line during the turnaround and data phase of a read, and captures the returned bits. Writing an all-zero command word starts no frame. It still produces a single MDC cycle, which some PHYs need before they leave reset.

Top module: `mdio_master`

## Requirements
- R1: Command register layout: bits 15:11 hold the PHY address, bits 10:6 the register number, bits 5:2 the clock-range code, bit 1 the direction (1 = write, 0 = read) and bit 0 busy. Reading it (reg_sel = 0) returns the stored fields with the live busy state in bit 0. Both registers read zero after reset, with MDC low and MDIO released.
- R2: The MDC period in system clocks follows the clock-range code: 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102, 5 gives 124, and every other code gives 124.
- R3: A command write with bit 0 set and bit 1 set sends 64 MDC cycles carrying 32 ones, start 01, opcode 01, the 5-bit address, the 5-bit register number, turnaround 10, and the 16 data-register bits, all MSB first, with MDIO driven throughout.
- R4: A command write with bit 0 set and bit 1 clear sends 32 ones, start 01, opcode 10, then address and register number. MDIO is released (mdio_oe low) for the final 18 bit times, which cover the turnaround and the data phase.
- R5: During a read, MDIO is sampled on each of the 16 rising MDC edges of the data phase, MSB first. The result appears in the data register (reg_sel = 1) once busy has cleared.
- R6: Busy reads 1 from the clock edge that accepts a starting command until the frame ends, then clears by itself. At that point the direction, address, register and clock-range fields are left unchanged.
- R7: While busy is 1, writes to either register are ignored. A frame in flight is not altered, and the register contents are unchanged when it ends.
- R8: Writing the all-zero command word while idle produces exactly one MDC cycle (one rising and one falling edge) at the code-0 ratio, with MDIO released for the whole cycle. A non-zero command word with bit 0 clear is stored and produces no MDC activity.
- R9: When idle, MDC is held low and MDIO is released. During a frame, the MDIO output changes only at falling MDC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Value of the register chosen by reg_sel |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bench models a PHY that records every bit on rising MDC and returns read data on falling MDC. Each frame is compared bit for bit, so an off-by-one in the shifter, a swapped opcode or a wrong turnaround shows up as a different 64-bit pattern. It also checks that the output enable falls at exactly bit 46, since a controller that released one bit late would fight the PHY on the bus.

The MDC period is measured for every clock-range code, including an undefined one, which catches a wrong ratio table or a missing default. Register writes made in the middle of a frame must leave both the frame and the register contents intact. The all-zero command must produce exactly one MDC edge pair. A design that skipped that pulse, or started a frame for it, would show zero or 64 rising edges instead.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int DRIVE_LEN  = 46;
  localparam int DATA_START = 48;
  localparam int DATA_W     = 16;
  localparam int HALF_W     = 7;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FRAME = 2'd1,
    ENG_PULSE = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [3:0] csr;
    logic       wr;
  } cmd_t;

  // half period of MDC in system clocks for a clock-range code
  function automatic logic [HALF_W-1:0] half_div(input logic [3:0] code);
    case (code)
      4'd0:    half_div = HALF_W'(21);
      4'd1:    half_div = HALF_W'(31);
      4'd2:    half_div = HALF_W'(8);
      4'd3:    half_div = HALF_W'(13);
      4'd4:    half_div = HALF_W'(51);
      default: half_div = HALF_W'(62);
    endcase
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
#(
  parameter int CNT_W = HALF_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       mdc,
  output logic       rise_p,
  output logic       fall_p
);
  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             mdc_q, mdc_d, wrap;

  assign half_m1 = CNT_W'(half_div(code)) - CNT_W'(1);
  assign wrap    = run && (cnt_q == half_m1);
  assign rise_p  = wrap && !mdc_q;
  assign fall_p  = wrap && mdc_q;
  assign mdc     = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R9
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_frame,
  input  logic              start_pulse,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mdio_i,
  output logic              run,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  eng_state_e             state_q, state_d;
  logic [FRAME_LEN-1:0]   sh_q, sh_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   wr_q, wr_d;
  logic [DATA_W-1:0]      cap_q, cap_d;
  logic                   last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign run      = (state_q != ENG_IDLE);
  assign done     = (state_q == ENG_FRAME) && fall_p && last_bit;
  assign mdio_oe  = (state_q == ENG_FRAME) && (wr_q || (idx_q < IDX_W'(DRIVE_LEN)));
  assign mdio_o   = sh_q[FRAME_LEN-1] && mdio_oe;
  assign rdata    = cap_q;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    wr_d    = wr_q;
    cap_d   = cap_q;
    case (state_q)
      ENG_IDLE: begin
        if (start_frame) begin
          state_d = ENG_FRAME;
          idx_d   = '0;
          wr_d    = cmd.wr;
          sh_d    = {{PRE_LEN{1'b1}}, 2'b01,
                     (cmd.wr ? 2'b01 : 2'b10),
                     cmd.phy, cmd.regn, 2'b10,
                     (cmd.wr ? wdata : {DATA_W{1'b1}})};
        end else if (start_pulse) begin
          state_d = ENG_PULSE;
        end
      end
      ENG_FRAME: begin
        if (rise_p && !wr_q && (idx_q >= IDX_W'(DATA_START)))
          cap_d = {cap_q[DATA_W-2:0], mdio_i};
        if (fall_p) begin
          if (last_bit) begin
            state_d = ENG_IDLE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
          end
        end
      end
      ENG_PULSE: begin
        if (fall_p) state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      cap_q   <= cap_d;
    end
  end

  // R9
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_FRAME && !fall_p) |=> $stable(mdio_o));

  // R8
  pulse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_PULSE) |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  cmd_t              cmd_q, cmd_d, new_cmd;
  logic [DATA_W-1:0] data_q, data_d, eng_rdata;
  logic              busy, eng_done, cmd_acc, start_frame, start_pulse;
  logic              rise_p, fall_p;

  assign new_cmd     = '{phy: reg_wdata[15:11], regn: reg_wdata[10:6],
                         csr: reg_wdata[5:2], wr: reg_wdata[1]};
  assign cmd_acc     = reg_we && !reg_sel && !busy;
  assign start_frame = cmd_acc && reg_wdata[0];
  assign start_pulse = cmd_acc && (reg_wdata == 16'h0000);

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    if (cmd_acc) cmd_d = new_cmd;
    if (reg_we && reg_sel && !busy)
      data_d = reg_wdata;
    else if (eng_done && !cmd_q.wr)
      data_d = eng_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  assign reg_rdata = reg_sel ? data_q
                             : {cmd_q.phy, cmd_q.regn, cmd_q.csr, cmd_q.wr, busy};

  mdio_mdc_gen u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .code   (cmd_q.csr),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_frame_eng u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_frame (start_frame),
    .start_pulse (start_pulse),
    .cmd         (new_cmd),
    .wdata       (data_q),
    .rise_p      (rise_p),
    .fall_p      (fall_p),
    .mdio_i      (mdio_i),
    .run         (busy),
    .done        (eng_done),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .rdata       (eng_rdata)
  );

  // R7
  data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel && !eng_done) |=> $stable(data_q));

  // R7
  cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && !reg_sel) |=> $stable(cmd_q));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !busy);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_frame |=> busy);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk, rst_n, reg_we, reg_sel, mdio_i;
  logic [15:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // bits: [30] write, [29:26] code, [25:21] phy, [20:16] reg, [15:0] data
  localparam logic [30:0] VEC [8] = '{
    {1'b1, 4'd2, 5'd1,  5'd2,  16'hA5C3},
    {1'b0, 4'd3, 5'd4,  5'd17, 16'h3C5A},
    {1'b1, 4'd0, 5'd31, 5'd0,  16'hFFFF},
    {1'b0, 4'd1, 5'd0,  5'd31, 16'h8001},
    {1'b1, 4'd4, 5'd16, 5'd1,  16'h0000},
    {1'b0, 4'd5, 5'd10, 5'd21, 16'hFFFF},
    {1'b1, 4'd9, 5'd21, 5'd10, 16'h1234},
    {1'b0, 4'd2, 5'd31, 5'd31, 16'h0000}
  };

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  // PHY model: records bits on rising MDC, returns data on falling MDC
  logic [63:0] frame_cap = '0;
  logic [63:0] oe_cap = '0;
  int rise_total = 0;
  int last_rise_cyc = 0;
  int period = 0;
  int start_total = 0;
  logic [15:0] phy_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    frame_cap = {frame_cap[62:0], mdio_o};
    oe_cap    = {oe_cap[62:0], mdio_oe};
    period    = cyc - last_rise_cyc;
    last_rise_cyc = cyc;
    rise_total = rise_total + 1;
  end

  always @(negedge mdc) begin
    int n;
    n = rise_total - start_total;
    if (n >= 48 && n <= 63) mdio_i = phy_data[63 - n];
    else mdio_i = 1'b1;
  end

  function automatic int ratio(input logic [3:0] c);
    case (c)
      4'd0: return 42;
      4'd1: return 62;
      4'd2: return 16;
      4'd3: return 26;
      4'd4: return 102;
      4'd5: return 124;
      default: return 124;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd_reg(1'b0, v);
      if (!v[0]) break;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [63:0] exp_frame, exp_oe;
    reg_we = 0; reg_sel = 0; reg_wdata = 0; mdio_i = 1'b1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_reg(1'b0, v);
    check(v == 16'h0, "R1 reset cmd", 64'(v), 64'h0);
    rd_reg(1'b1, v);
    check(v == 16'h0, "R1 reset data", 64'(v), 64'h0);
    check(!mdc && !mdio_oe, "R9 reset idle bus", {62'b0, mdc, mdio_oe}, 64'h0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic        w;
      logic [3:0]  c;
      logic [4:0]  p, r;
      logic [15:0] d;
      logic [15:0] cmdw;
      {w, c, p, r, d} = VEC[i];
      cmdw = {p, r, c, w, 1'b1};
      phy_data = d;
      start_total = rise_total;
      if (w) wr_reg(1'b1, d);
      wr_reg(1'b0, cmdw);
      rd_reg(1'b0, v);
      check(v[0] == 1'b1, "R6 busy set", 64'(v), 64'(cmdw));
      wait_idle();
      check(rise_total - start_total == 64, "R3 R4 edge count",
            64'(rise_total - start_total), 64'd64);
      if (w) begin
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
        exp_oe    = '1;
        check(frame_cap == exp_frame, "R3 write frame", frame_cap, exp_frame);
        check(oe_cap == exp_oe, "R3 drive enable", oe_cap, exp_oe);
      end else begin
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'b0};
        exp_oe    = ~64'h3FFFF;
        check(frame_cap == exp_frame, "R4 read frame", frame_cap, exp_frame);
        check(oe_cap == exp_oe, "R4 release window", oe_cap, exp_oe);
      end
      check(period == ratio(c), "R2 mdc period", 64'(period), 64'(ratio(c)));
      rd_reg(1'b1, v);
      check(v == d, w ? "R3 data kept" : "R5 read data", 64'(v), 64'(d));
      rd_reg(1'b0, v);
      check(v == {p, r, c, w, 1'b0}, "R6 cmd after done", 64'(v), 64'({p, r, c, w, 1'b0}));
      check(!mdc && !mdio_oe, "R9 idle after frame", {62'b0, mdc, mdio_oe}, 64'h0);
    end

    // R7: writes during a frame are ignored
    start_total = rise_total;
    wr_reg(1'b1, 16'hC0DE);
    wr_reg(1'b0, {5'd3, 5'd7, 4'd2, 1'b1, 1'b1});
    repeat (100) @(negedge clk);
    wr_reg(1'b1, 16'h0BAD);
    wr_reg(1'b0, {5'd9, 5'd9, 4'd0, 1'b0, 1'b1});
    wait_idle();
    exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd7, 2'b10, 16'hC0DE};
    check(frame_cap == exp_frame, "R7 frame intact", frame_cap, exp_frame);
    rd_reg(1'b1, v);
    check(v == 16'hC0DE, "R7 data unchanged", 64'(v), 64'hC0DE);
    rd_reg(1'b0, v);
    check(v == {5'd3, 5'd7, 4'd2, 1'b1, 1'b0}, "R7 cmd unchanged", 64'(v),
          64'({5'd3, 5'd7, 4'd2, 1'b1, 1'b0}));

    // R8: all-zero command gives one MDC cycle with bus released
    start_total = rise_total;
    wr_reg(1'b0, 16'h0000);
    wait_idle();
    repeat (50) @(negedge clk);
    check(rise_total - start_total == 1, "R8 single mdc", 64'(rise_total - start_total), 64'd1);
    check(oe_cap[0] == 1'b0, "R8 released", 64'(oe_cap[0]), 64'h0);
    check(!mdc, "R8 mdc low after", 64'(mdc), 64'h0);

    // R8: non-zero command with busy clear is stored, no MDC
    start_total = rise_total;
    wr_reg(1'b0, {5'd5, 5'd6, 4'd3, 1'b1, 1'b0});
    repeat (200) @(negedge clk);
    check(rise_total == start_total, "R8 no activity", 64'(rise_total - start_total), 64'h0);
    rd_reg(1'b0, v);
    check(v == {5'd5, 5'd6, 4'd3, 1'b1, 1'b0}, "R1 stored fields", 64'(v),
          64'({5'd5, 5'd6, 4'd3, 1'b1, 1'b0}));
    check(!mdio_oe, "R9 released idle", 64'(mdio_oe), 64'h0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule